// File: doc/BRIEF.md
# External Interrupt Acceptance Controller

This block sits beside a processor core and rules on each interrupt request that an external interrupt controller presents. A request carries a handler address, the register set the handler wants to run in, a priority level and a flag marking it as nonmaskable. The block compares these against its own status state and grants or refuses the request. The status state holds the interrupt enable, the register-set nesting override, the nonmaskable-in-service lockout, the current level and the current register set.

On a grant, the block saves the whole status into a shadow copy and loads the new level and register set. It also clears the interrupt enable and, for a nonmaskable request, sets the lockout. For one cycle it raises a take pulse carrying the handler address and the register set. A return pulse copies the saved status back. Software can rewrite the enable, the override and the level through a write port. A parameter picks whether shadow register sets exist. Without them, the register-set rule is skipped and the current set stays at 0.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset, enable, override, lockout, level, current set and take all read 0.
- R2: A valid nonmaskable request (`req_nmi`=1) is granted exactly when the lockout bit is 0, whatever the enable, level and set.
- R3: A valid maskable request is refused while the enable bit is 0.
- R4: A valid maskable request is refused unless `req_level` is strictly greater than the current level, compared as unsigned numbers.
- R5: With shadow sets (`SHADOW_SETS`>0), a maskable request that passes R3 and R4 is granted only if `req_set` differs from the current set or the override bit is 1.
- R6: Without shadow sets (`SHADOW_SETS`=0), the set rule is skipped, and the current set and `take_set` stay 0.
- R7: On a grant, at the next clock edge:
  - `take` goes high for one cycle, with `take_handler` equal to the request's address and `take_set` equal to the new current set.
  - The prior status is saved.
  - The enable bit clears.
  - The level becomes `req_level` and the current set becomes `req_set`.
  - The lockout bit is set if the request was nonmaskable and otherwise keeps its value.
- R8: A cycle with `eret`=1 restores the whole status from the saved copy, and any request in that cycle is refused.
- R9: With `sw_wr`=1 the enable, override and level take `sw_pie`, `sw_rsie`, `sw_level`, unless a grant or a return happens in the same cycle, which wins.
- R10: A refused or invalid request, with no return and no write, leaves every status output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request fields are valid this cycle |
| req_handler | input | ADDR_W | Handler address of the request |
| req_set | input | SET_W | Requested register set |
| req_level | input | LVL_W | Requested priority level |
| req_nmi | input | 1 | Request is nonmaskable |
| eret | input | 1 | Return from exception, one-cycle pulse |
| sw_wr | input | 1 | Software write strobe |
| sw_pie | input | 1 | Written enable value |
| sw_rsie | input | 1 | Written set-override value |
| sw_level | input | LVL_W | Written level value |
| take | output | 1 | One-cycle grant pulse |
| take_handler | output | ADDR_W | Address of the granted handler |
| take_set | output | SET_W | Register set the granted handler runs in |
| stat_pie | output | 1 | Current interrupt enable |
| stat_rsie | output | 1 | Current same-set nesting override |
| stat_nmi | output | 1 | Nonmaskable service lockout |
| stat_level | output | LVL_W | Current level |
| stat_crs | output | SET_W | Current register set |

## Verification
The properties assume that `eret` comes only as a pulse meant to undo a grant. They also assume that in a build without shadow sets, `req_set` is held at 0. The bench keeps to both rules: it drives the flat instance's set input with a constant 0. It raises `eret` only after a grant whose prior status it knows. The sweep reaches every status combination through legal grants and software writes, never by forcing state. It then applies every request pattern, sometimes alongside a competing write or return.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    // Outcome of the acceptance rules for one request
    typedef enum logic [2:0] {
        V_IDLE      = 3'd0,
        V_NMI_OK    = 3'd1,
        V_NMI_BUSY  = 3'd2,
        V_MASKED    = 3'd3,
        V_LOW_LEVEL = 3'd4,
        V_SET_BUSY  = 3'd5,
        V_OK        = 3'd6
    } verdict_e;

    function automatic logic verdict_grants(verdict_e v);
        return (v == V_NMI_OK) || (v == V_OK);
    endfunction

endpackage

// File: rtl/irq_accept_decide.sv
module irq_accept_decide
    import irq_accept_pkg::*;
#(
    parameter int LVL_W      = 6,
    parameter int SET_W      = 2,
    parameter bit HAS_SHADOW = 1'b1
) (
    input  logic             req_valid,
    input  logic             req_nmi,
    input  logic [LVL_W-1:0] req_level,
    input  logic [SET_W-1:0] req_set,
    input  logic             cur_pie,
    input  logic             cur_rsie,
    input  logic             cur_nmi,
    input  logic [LVL_W-1:0] cur_level,
    input  logic [SET_W-1:0] cur_crs,
    output verdict_e         verdict,
    output logic             grant
);

    logic set_clear;

    generate
        if (HAS_SHADOW) begin : g_shadow
            // same-set nesting needs the software override
            assign set_clear = (req_set != cur_crs) || cur_rsie;
        end else begin : g_flat
            assign set_clear = 1'b1;
        end
    endgenerate

    always_comb begin
        if (!req_valid) begin
            verdict = V_IDLE;
        end else if (req_nmi) begin
            verdict = cur_nmi ? V_NMI_BUSY : V_NMI_OK;
        end else if (!cur_pie) begin
            verdict = V_MASKED;
        end else if (req_level <= cur_level) begin
            verdict = V_LOW_LEVEL;
        end else if (!set_clear) begin
            verdict = V_SET_BUSY;
        end else begin
            verdict = V_OK;
        end
        grant = verdict_grants(verdict);
    end

endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs #(
    parameter int ADDR_W     = 32,
    parameter int LVL_W      = 6,
    parameter int SET_W      = 2,
    parameter bit HAS_SHADOW = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic [ADDR_W-1:0] req_handler,
    input  logic [SET_W-1:0]  req_set,
    input  logic [LVL_W-1:0]  req_level,
    input  logic              req_nmi,
    input  logic              eret,
    input  logic              sw_wr,
    input  logic              sw_pie,
    input  logic              sw_rsie,
    input  logic [LVL_W-1:0]  sw_level,
    output logic              take,
    output logic [ADDR_W-1:0] take_handler,
    output logic [SET_W-1:0]  take_set,
    output logic              cur_pie,
    output logic              cur_rsie,
    output logic              cur_nmi,
    output logic [LVL_W-1:0]  cur_level,
    output logic [SET_W-1:0]  cur_crs
);

    typedef struct packed {
        logic             pie;
        logic             rsie;
        logic             nmi;
        logic [LVL_W-1:0] level;
        logic [SET_W-1:0] crs;
    } stat_t;

    typedef struct packed {
        stat_t             cur;
        stat_t             saved;
        logic              take;
        logic [ADDR_W-1:0] handler;
        logic [SET_W-1:0]  hset;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        if (eret) begin
            st_d.cur = st_q.saved;
        end else if (grant) begin
            st_d.saved     = st_q.cur;
            st_d.cur.pie   = 1'b0;
            st_d.cur.level = req_level;
            st_d.cur.crs   = HAS_SHADOW ? req_set : '0;
            st_d.cur.nmi   = st_q.cur.nmi | req_nmi;
            st_d.take      = 1'b1;
            st_d.handler   = req_handler;
            st_d.hset      = HAS_SHADOW ? req_set : '0;
        end else if (sw_wr) begin
            st_d.cur.pie   = sw_pie;
            st_d.cur.rsie  = sw_rsie;
            st_d.cur.level = sw_level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take         = st_q.take;
    assign take_handler = st_q.handler;
    assign take_set     = st_q.hset;
    assign cur_pie      = st_q.cur.pie;
    assign cur_rsie     = st_q.cur.rsie;
    assign cur_nmi      = st_q.cur.nmi;
    assign cur_level    = st_q.cur.level;
    assign cur_crs      = st_q.cur.crs;

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
    import irq_accept_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LVL_W       = 6,
    parameter int SHADOW_SETS = 3,
    localparam int SET_W      = (SHADOW_SETS > 0) ? $clog2(SHADOW_SETS + 1) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_handler,
    input  logic [SET_W-1:0]  req_set,
    input  logic [LVL_W-1:0]  req_level,
    input  logic              req_nmi,
    input  logic              eret,
    input  logic              sw_wr,
    input  logic              sw_pie,
    input  logic              sw_rsie,
    input  logic [LVL_W-1:0]  sw_level,
    output logic              take,
    output logic [ADDR_W-1:0] take_handler,
    output logic [SET_W-1:0]  take_set,
    output logic              stat_pie,
    output logic              stat_rsie,
    output logic              stat_nmi,
    output logic [LVL_W-1:0]  stat_level,
    output logic [SET_W-1:0]  stat_crs
);

    localparam bit HAS_SHADOW = (SHADOW_SETS > 0);

    verdict_e verdict;
    logic     rule_ok;
    logic     grant;

    irq_accept_decide #(
        .LVL_W      (LVL_W),
        .SET_W      (SET_W),
        .HAS_SHADOW (HAS_SHADOW)
    ) u_decide (
        .req_valid (req_valid),
        .req_nmi   (req_nmi),
        .req_level (req_level),
        .req_set   (req_set),
        .cur_pie   (stat_pie),
        .cur_rsie  (stat_rsie),
        .cur_nmi   (stat_nmi),
        .cur_level (stat_level),
        .cur_crs   (stat_crs),
        .verdict   (verdict),
        .grant     (rule_ok)
    );

    // a return in the same cycle blocks any grant
    assign grant = rule_ok & ~eret;

    irq_status_regs #(
        .ADDR_W     (ADDR_W),
        .LVL_W      (LVL_W),
        .SET_W      (SET_W),
        .HAS_SHADOW (HAS_SHADOW)
    ) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .grant        (grant),
        .req_handler  (req_handler),
        .req_set      (req_set),
        .req_level    (req_level),
        .req_nmi      (req_nmi),
        .eret         (eret),
        .sw_wr        (sw_wr),
        .sw_pie       (sw_pie),
        .sw_rsie      (sw_rsie),
        .sw_level     (sw_level),
        .take         (take),
        .take_handler (take_handler),
        .take_set     (take_set),
        .cur_pie      (stat_pie),
        .cur_rsie     (stat_rsie),
        .cur_nmi      (stat_nmi),
        .cur_level    (stat_level),
        .cur_crs      (stat_crs)
    );

endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
    parameter int ADDR_W      = 32,
    parameter int LVL_W       = 6,
    parameter int SHADOW_SETS = 3,
    parameter int SET_W       = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_handler,
    input logic [SET_W-1:0]  req_set,
    input logic [LVL_W-1:0]  req_level,
    input logic              req_nmi,
    input logic              eret,
    input logic              sw_wr,
    input logic              sw_pie,
    input logic              sw_rsie,
    input logic [LVL_W-1:0]  sw_level,
    input logic              take,
    input logic [ADDR_W-1:0] take_handler,
    input logic [SET_W-1:0]  take_set,
    input logic              stat_pie,
    input logic              stat_rsie,
    input logic              stat_nmi,
    input logic [LVL_W-1:0]  stat_level,
    input logic [SET_W-1:0]  stat_crs
);

    // R2
    nmi_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_nmi && stat_nmi |=> !take);

    // R2
    nmi_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_nmi && !stat_nmi && !eret |=> take);

    // R3
    masked_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_nmi && !stat_pie |=> !take);

    // R4
    level_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_nmi && (req_level <= stat_level) |=> !take);

    // R7
    take_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !stat_pie && (take_set == stat_crs));

    // R7
    take_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !eret && !stat_nmi && req_nmi
        |=> take_handler == $past(req_handler) && stat_level == $past(req_level));

    // R8
    eret_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eret |=> !take);

    // R10
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid && !eret && !sw_wr
        |=> $stable({stat_pie, stat_rsie, stat_nmi, stat_level, stat_crs}));

    // R9
    sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr && !req_valid && !eret
        |=> stat_pie == $past(sw_pie) && stat_rsie == $past(sw_rsie)
            && stat_level == $past(sw_level));

    generate
        if (SHADOW_SETS == 0) begin : g_flat_chk
            // R6
            flat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                stat_crs == '0 && take_set == '0);
        end
    endgenerate

endmodule

bind irq_accept_ctrl irq_accept_chk #(
    .ADDR_W      (ADDR_W),
    .LVL_W       (LVL_W),
    .SHADOW_SETS (SHADOW_SETS),
    .SET_W       (SET_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_handler  (req_handler),
    .req_set      (req_set),
    .req_level    (req_level),
    .req_nmi      (req_nmi),
    .eret         (eret),
    .sw_wr        (sw_wr),
    .sw_pie       (sw_pie),
    .sw_rsie      (sw_rsie),
    .sw_level     (sw_level),
    .take         (take),
    .take_handler (take_handler),
    .take_set     (take_set),
    .stat_pie     (stat_pie),
    .stat_rsie    (stat_rsie),
    .stat_nmi     (stat_nmi),
    .stat_level   (stat_level),
    .stat_crs     (stat_crs)
);

// File: tb/tb_irq_accept_ctrl.sv
`timescale 1ns/1ps
module tb_irq_accept_ctrl;

    localparam int AW = 8;
    localparam int LW = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          req_valid, req_nmi, eret, sw_wr, sw_pie, sw_rsie;
    logic [AW-1:0] req_handler;
    logic [0:0]    req_set;
    logic [LW-1:0] req_level, sw_level;

    logic          take_a, pie_a, rsie_a, nmi_a;
    logic [AW-1:0] hand_a;
    logic [0:0]    set_a, crs_a;
    logic [LW-1:0] lvl_a;
    logic          take_b, pie_b, rsie_b, nmi_b;
    logic [AW-1:0] hand_b;
    logic [0:0]    set_b, crs_b;
    logic [LW-1:0] lvl_b;

    irq_accept_ctrl #(.ADDR_W(AW), .LVL_W(LW), .SHADOW_SETS(1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_handler(req_handler),
        .req_set(req_set), .req_level(req_level), .req_nmi(req_nmi), .eret(eret),
        .sw_wr(sw_wr), .sw_pie(sw_pie), .sw_rsie(sw_rsie), .sw_level(sw_level),
        .take(take_a), .take_handler(hand_a), .take_set(set_a), .stat_pie(pie_a),
        .stat_rsie(rsie_a), .stat_nmi(nmi_a), .stat_level(lvl_a), .stat_crs(crs_a));

    irq_accept_ctrl #(.ADDR_W(AW), .LVL_W(LW), .SHADOW_SETS(0)) dut_flat (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_handler(req_handler),
        .req_set(1'b0), .req_level(req_level), .req_nmi(req_nmi), .eret(eret),
        .sw_wr(sw_wr), .sw_pie(sw_pie), .sw_rsie(sw_rsie), .sw_level(sw_level),
        .take(take_b), .take_handler(hand_b), .take_set(set_b), .stat_pie(pie_b),
        .stat_rsie(rsie_b), .stat_nmi(nmi_b), .stat_level(lvl_b), .stat_crs(crs_b));

    typedef struct {
        bit pie;
        bit rsie;
        bit nmi;
        int lvl;
        int crs;
    } st_t;

    st_t cur [2];
    st_t sav [2];
    bit  etake [2];
    int  ehand [2];
    int  eset [2];
    string dtag [2];
    string stag [2];

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            cur[k] = '{0, 0, 0, 0, 0};
            sav[k] = '{0, 0, 0, 0, 0};
            etake[k] = 0;
        end
    endtask

    // acceptance rules from R2..R6, R8; k==0 has shadow sets
    function automatic bit rules(int k, st_t s, int rset, output string tag);
        if (!req_valid) begin tag = "R10"; return 0; end
        if (req_nmi) begin tag = "R2"; return !s.nmi; end
        if (!s.pie) begin tag = "R3"; return 0; end
        if (int'(req_level) <= s.lvl) begin tag = "R4"; return 0; end
        if (k == 0) begin
            tag = "R5";
            return (rset != s.crs) || s.rsie;
        end
        tag = "R6";
        return 1;
    endfunction

    task automatic tick();
        for (int k = 0; k < 2; k++) begin
            int    rset;
            bit    acc;
            string tg;
            rset = (k == 0) ? int'(req_set) : 0;
            acc  = rules(k, cur[k], rset, tg);
            if (eret) begin
                acc = 0;
                tg  = "R8";
            end
            dtag[k]  = tg;
            etake[k] = acc;
            if (eret) begin
                cur[k]  = sav[k];
                stag[k] = "R8";
            end else if (acc) begin
                sav[k]      = cur[k];
                cur[k].pie  = 0;
                cur[k].lvl  = int'(req_level);
                cur[k].crs  = rset;
                cur[k].nmi  = cur[k].nmi | req_nmi;
                ehand[k]    = int'(req_handler);
                eset[k]     = rset;
                stag[k]     = "R7";
            end else if (sw_wr) begin
                cur[k].pie  = sw_pie;
                cur[k].rsie = sw_rsie;
                cur[k].lvl  = int'(sw_level);
                stag[k]     = "R9";
            end else begin
                stag[k] = "R10";
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare();
        req_valid = 0; eret = 0; sw_wr = 0;
    endtask

    task automatic compare();
        chk(dtag[0], "take", int'(take_a), int'(etake[0]));
        chk(dtag[1], "flat take", int'(take_b), int'(etake[1]));
        if (etake[0]) begin
            chk("R7", "handler", int'(hand_a), ehand[0]);
            chk("R7", "take_set", int'(set_a), eset[0]);
        end
        if (etake[1]) begin
            chk("R7", "flat handler", int'(hand_b), ehand[1]);
            chk("R6", "flat take_set", int'(set_b), 0);
        end
        chk(stag[0], "pie", int'(pie_a), int'(cur[0].pie));
        chk(stag[0], "rsie", int'(rsie_a), int'(cur[0].rsie));
        chk(stag[0], "nmi", int'(nmi_a), int'(cur[0].nmi));
        chk(stag[0], "level", int'(lvl_a), cur[0].lvl);
        chk(stag[0], "crs", int'(crs_a), cur[0].crs);
        chk(stag[1], "flat pie", int'(pie_b), int'(cur[1].pie));
        chk(stag[1], "flat nmi", int'(nmi_b), int'(cur[1].nmi));
        chk(stag[1], "flat level", int'(lvl_b), cur[1].lvl);
        chk("R6", "flat crs", int'(crs_b), 0);
    endtask

    task automatic do_reset();
        rst_n = 0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        rst_n = 0; req_valid = 0; req_nmi = 0; eret = 0; sw_wr = 0;
        sw_pie = 0; sw_rsie = 0; req_handler = '0; req_set = '0;
        req_level = '0; sw_level = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
        // R1: reset state
        chk("R1", "take", int'(take_a), 0);
        chk("R1", "pie", int'(pie_a), 0);
        chk("R1", "rsie", int'(rsie_a), 0);
        chk("R1", "nmi", int'(nmi_a), 0);
        chk("R1", "level", int'(lvl_a), 0);
        chk("R1", "crs", int'(crs_a), 0);

        for (int nm = 0; nm < 2; nm++)
        for (int cs = 0; cs < 2; cs++)
        for (int pe = 0; pe < 2; pe++)
        for (int rs = 0; rs < 2; rs++)
        for (int lv = 0; lv < 4; lv++)
        for (int qn = 0; qn < 2; qn++)
        for (int qs = 0; qs < 2; qs++)
        for (int ql = 0; ql < 4; ql++) begin
            do_reset();
            // reach lockout and current set through legal grants
            if (nm == 1) begin
                req_valid = 1; req_nmi = 1; req_set = 1'(cs); req_level = '0;
                req_handler = 8'hA5;
                tick();
            end else begin
                sw_wr = 1; sw_pie = 1; sw_rsie = 1; sw_level = '0;
                tick();
                req_valid = 1; req_nmi = 0; req_set = 1'(cs); req_level = 2'd3;
                req_handler = 8'h5A;
                tick();
            end
            sw_wr = 1; sw_pie = 1'(pe); sw_rsie = 1'(rs); sw_level = 2'(lv);
            tick();
            // the request under test, sometimes racing a software write
            req_valid = 1; req_nmi = 1'(qn); req_set = 1'(qs); req_level = 2'(ql);
            req_handler = 8'(ql * 16 + qs * 4 + qn * 2 + lv * 64 + 1);
            if (((ql + lv + qs) % 2) == 1) begin
                sw_wr = 1; sw_pie = 1'(1 - pe); sw_rsie = 1'(1 - rs); sw_level = 2'(ql ^ 1);
            end
            tick();
            // idle cycle: pulse must drop, state must hold (R10)
            tick();
            // return, with a request racing it on some patterns (R8)
            eret = 1;
            req_valid = 1'(ql % 2); req_nmi = 1'(qn); req_set = 1'(qs); req_level = 2'd3;
            tick();
        end
        done = 1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

endmodule